// File: doc/BRIEF.md
# Saturating Fractional Add/Subtract Unit

This block adds or subtracts two signed fixed-point operands. It treats the 32-bit inputs either as one Q31 word or as two independent packed Q15 halfwords. On every accepted operation it checks for signed overflow. Addition and subtraction use different sign rules. When saturation is enabled, an overflowing lane is clamped to its most positive or most negative value. When saturation is off, the lane keeps the wrapped two's-complement result.

Any overflow, saturated or wrapped, sets a sticky status flag in a 32-bit control/status word. Software clears or sets that flag through a write port. The result and the flag are registered, and both update on the clock edge where `in_valid` is high. The block suits a DSP datapath stage that needs saturating arithmetic alongside a cumulative overflow indication.

Top module: `sat_addsub_unit`

## Requirements
- R1: With `pair_mode`=0 and no overflow, `result` equals the 32-bit two's-complement sum (`op_sub`=0) or difference `op_a - op_b` (`op_sub`=1).
- R2: An addition overflows in a lane exactly when both operands have the same sign bit and the wrapped sum's sign bit differs from `op_a`'s.
- R3: A subtraction overflows in a lane exactly when the operands' sign bits differ and the wrapped difference's sign bit differs from `op_a`'s, e.g. word 0x00000000 - 0x80000000 overflows while 0x80000000 - 0x80000000 = 0 does not.
- R4: A saturating subtraction that overflows yields the lane maximum (0x7FFFFFFF word, 0x7FFF halfword) when the minuend is zero or positive, otherwise the lane minimum (0x80000000 / 0x8000).
- R5: A saturating addition that overflows yields the lane maximum when `op_a` is greater than zero, otherwise the lane minimum.
- R6: With `sat_en`=0 an overflowing lane returns the truncated two's-complement result, and the overflow flag is still set.
- R7: With `pair_mode`=1 the lanes occupy bits 15:0 and 31:16, and each lane computes, detects and saturates on its own with no carry between them. For example, 0x12340000 - 0x87658000 saturating gives 0x7FFF7FFF. Overflow in either lane sets the single flag.
- R8: The overflow flag is bit 20 of `ctl_q` and is sticky: once set, it stays set until a control write. All other `ctl_q` bits read 0.
- R9: When `ctl_we`=1, bit 20 of `ctl_q` loads `ctl_wdata[20]` on the next edge. This write wins over an overflow set in the same cycle.
- R10: After synchronous reset, `result` and `ctl_q` are 0. `result` changes only on an edge where `in_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept operands and update result/flag on this edge |
| op_a | input | 32 | First operand / minuend |
| op_b | input | 32 | Second operand / subtrahend |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| pair_mode | input | 1 | 1 = two Q15 lanes, 0 = one Q31 word |
| sat_en | input | 1 | 1 = saturate on overflow, 0 = wrap |
| ctl_we | input | 1 | Control/status write strobe |
| ctl_wdata | input | 32 | Control/status write data (bit 20 is the flag) |
| result | output | 32 | Registered result |
| ctl_q | output | 32 | Control/status word, bit 20 = sticky overflow |

## Verification
The in-RTL assertions check the control-side behaviour on every cycle. They confirm that the flag never drops without a write, that a write always decides the next flag value, that an overflowing accepted operation raises the flag, that the result holds while no operation is accepted, and that the unused status bits stay at zero. Only the bench can show the arithmetic: the exact saturated and wrapped values, the minuend-sign rule at zero, and lane independence in paired mode. It compares against a wide-integer range model that does not use the sign-XOR equations.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int DW       = 32;
    localparam int HW       = DW / 2;
    localparam int NLANES   = 2;
    localparam int FLAG_POS = 20;

    typedef enum logic { OP_ADD = 1'b0, OP_SUB = 1'b1 } op_e;
    typedef enum logic { LANE_WORD = 1'b0, LANE_PAIR = 1'b1 } lane_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          ovf;
    } dp_out_t;

    // Extreme value of a W-bit signed lane: negative selects the minimum.
    function automatic logic [DW-1:0] clamp_val(input int w, input logic neg);
        logic [DW-1:0] v;
        v = '0;
        for (int i = 0; i < w - 1; i++) v[i] = ~neg;
        v[w-1] = neg;
        return v;
    endfunction

endpackage

// File: rtl/sat_lane.sv
module sat_lane #(
    parameter int W = 16
) (
    input  logic         [W-1:0] a,
    input  logic         [W-1:0] b,
    input  sat_pkg::op_e         op,
    input  logic                 sat,
    output logic         [W-1:0] r,
    output logic                 ovf
);
    import sat_pkg::*;

    logic [W-1:0]  raw;
    logic          sa, sb, sr;
    logic [DW-1:0] ext;

    always_comb begin
        raw = (op == OP_SUB) ? (a - b) : (a + b);
        sa  = a[W-1];
        sb  = b[W-1];
        sr  = raw[W-1];
        // Add: like-signed inputs whose sum changes sign.
        // Sub: unlike-signed inputs whose difference leaves the minuend's sign.
        if (op == OP_SUB) ovf = (sa ^ sb) & (sa ^ sr);
        else              ovf = ~(sa ^ sb) & (sa ^ sr);
        // Clamp direction follows the first operand's sign. For subtraction a
        // zero minuend counts as positive. For addition a zero operand cannot
        // overflow, so "a > 0" reduces to the same sign test.
        ext = clamp_val(W, sa);
        r   = (ovf && sat) ? ext[W-1:0] : raw;
    end

endmodule

// File: rtl/sat_datapath.sv
module sat_datapath (
    input  logic            [sat_pkg::DW-1:0] a,
    input  logic            [sat_pkg::DW-1:0] b,
    input  sat_pkg::op_e                      op,
    input  sat_pkg::lane_e                    mode,
    input  logic                              sat,
    output sat_pkg::dp_out_t                  out
);
    import sat_pkg::*;

    logic [DW-1:0]     word_r;
    logic              word_ovf;
    logic [DW-1:0]     pair_r;
    logic [NLANES-1:0] pair_ovf;

    sat_lane #(.W(DW)) u_word (
        .a(a), .b(b), .op(op), .sat(sat), .r(word_r), .ovf(word_ovf)
    );

    for (genvar g = 0; g < NLANES; g++) begin : g_half
        sat_lane #(.W(HW)) u_half (
            .a   (a[g*HW +: HW]),
            .b   (b[g*HW +: HW]),
            .op  (op),
            .sat (sat),
            .r   (pair_r[g*HW +: HW]),
            .ovf (pair_ovf[g])
        );
    end

    always_comb begin
        if (mode == LANE_PAIR) begin
            out.data = pair_r;
            out.ovf  = |pair_ovf;
        end else begin
            out.data = word_r;
            out.ovf  = word_ovf;
        end
    end

endmodule

// File: rtl/sat_status.sv
module sat_status #(
    parameter int W   = 32,
    parameter int POS = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (we)  flag_q <= wdata[POS];
        else if (set) flag_q <= 1'b1;
    end

    always_comb begin
        q      = '0;
        q[POS] = flag_q;
    end

    // R8: the flag only falls through a write
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (q[POS] && !we) |=> q[POS]);
    // R9: a write decides the next flag value, whatever the set input does
    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        we |=> (q[POS] == $past(wdata[POS])));
    // R8: bits other than the flag stay zero
    a_r8_other_zero: assert property (@(posedge clk) disable iff (rst)
        $countones(q) <= 1);

endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit #(
    parameter int DATA_W   = sat_pkg::DW,
    parameter int FLAG_POS = sat_pkg::FLAG_POS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              op_sub,
    input  logic              pair_mode,
    input  logic              sat_en,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] ctl_q
);
    import sat_pkg::*;

    dp_out_t       dp;
    op_e           op;
    lane_e         mode;
    logic [DW-1:0] res_q;

    assign op   = op_e'(op_sub);
    assign mode = lane_e'(pair_mode);

    sat_datapath u_dp (
        .a(op_a), .b(op_b), .op(op), .mode(mode), .sat(sat_en), .out(dp)
    );

    always_ff @(posedge clk) begin
        if (rst)           res_q <= '0;
        else if (in_valid) res_q <= dp.data;
    end

    assign result = res_q;

    sat_status #(.W(DATA_W), .POS(FLAG_POS)) u_status (
        .clk(clk), .rst(rst), .set(in_valid && dp.ovf),
        .we(ctl_we), .wdata(ctl_wdata), .q(ctl_q)
    );

    // R10: no accepted operation, no change of result
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
    // R6: an accepted overflow raises the flag unless a write overrides it
    a_r6_flag_raise: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dp.ovf && !ctl_we) |=> ctl_q[FLAG_POS]);
    // R4: saturated overflow result is a lane extreme in word mode
    a_r4_word_extreme: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dp.ovf && sat_en && !pair_mode) |=>
        (result == 32'h7FFF_FFFF || result == 32'h8000_0000));

endmodule

// File: tb/tb_sat_addsub_unit.sv
`timescale 1ns/1ps
module tb_sat_addsub_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, op_sub, pair_mode, sat_en, ctl_we;
    logic [31:0] op_a, op_b, ctl_wdata, result, ctl_q;

    int vectors = 0;
    int misses  = 0;
    logic flag_exp = 1'b0;
    logic [31:0] res_exp = '0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    sat_addsub_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .op_sub(op_sub), .pair_mode(pair_mode), .sat_en(sat_en),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .result(result), .ctl_q(ctl_q)
    );

    // Range-based lane model: exact integer result, then compare to limits.
    function automatic void lane_ref(input int w, input logic [31:0] a, input logic [31:0] b,
                                     input bit sub, input bit sat,
                                     output logic [31:0] r, output bit ov);
        longint sa, sb, s, mx, mn;
        if (w == 16) begin
            sa = longint'($signed(a[15:0])); sb = longint'($signed(b[15:0]));
        end else begin
            sa = longint'($signed(a)); sb = longint'($signed(b));
        end
        mx = (longint'(1) << (w - 1)) - 1;
        mn = -(longint'(1) << (w - 1));
        s  = sub ? sa - sb : sa + sb;
        ov = (s > mx) || (s < mn);
        if (ov && sat) s = (sa >= 0) ? mx : mn;
        r = 32'(s);
        if (w == 16) r = {16'h0, r[15:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input bit sub,
                         input bit pair, input bit sat, input bit we, input bit wbit);
        logic [31:0] rl, rh, rw;
        bit ol, oh, ow, ov;
        string tag;
        @(negedge clk);
        op_a = a; op_b = b; op_sub = sub; pair_mode = pair; sat_en = sat;
        in_valid = 1'b1; ctl_we = we; ctl_wdata = we ? (32'(wbit) << 20) : 32'h0;
        if (pair) begin
            lane_ref(16, a, b, sub, sat, rl, ol);
            lane_ref(16, a >> 16, b >> 16, sub, sat, rh, oh);
            res_exp = {rh[15:0], rl[15:0]}; ov = ol | oh; tag = "R7";
        end else begin
            lane_ref(32, a, b, sub, sat, rw, ow);
            res_exp = rw; ov = ow;
            if (!ov) tag = "R1";
            else if (!sat) tag = "R6";
            else tag = sub ? "R4" : "R5";
        end
        flag_exp = we ? wbit : (flag_exp | ov);
        @(negedge clk);
        in_valid = 1'b0; ctl_we = 1'b0;
        check(tag, result, res_exp);
        check(we ? "R9" : (sub ? "R3 flag" : "R2 flag"), ctl_q, 32'(flag_exp) << 20);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 32'h0;
        @(negedge clk);
        ctl_we = 1'b0; flag_exp = 1'b0;
        check("R9 clear", ctl_q, 32'h0);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'h8000_0000;
            1: return 32'h7FFF_FFFF;
            2: return 32'h0;
            3: return 32'h8000_7FFF;
            4: return 32'h7FFF_8000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            misses++; vectors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        rst = 1'b1; in_valid = 0; op_a = '1; op_b = '1; op_sub = 0;
        pair_mode = 0; sat_en = 0; ctl_we = 0; ctl_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check("R10 reset result", result, 32'h0);
        check("R10 reset ctl", ctl_q, 32'h0);

        // R3/R4 directed subtraction corners
        apply(32'h0006_6666, 32'h0005_5555, 1, 0, 1, 0, 0);
        apply(32'h8000_0000, 32'h8000_0000, 1, 0, 1, 0, 0);
        apply(32'h0000_0000, 32'h8000_0000, 1, 0, 1, 0, 0);
        check("R4 zero minuend", result, 32'h7FFF_FFFF);
        clear_flag();
        apply(32'h1234_0000, 32'h8765_8000, 1, 1, 1, 0, 0);
        check("R7 pair example", result, 32'h7FFF_7FFF);
        // R8 sticky across a clean operation
        apply(32'h0000_0001, 32'h0000_0001, 0, 0, 1, 0, 0);
        check("R8 sticky", ctl_q, 32'h0010_0000);
        clear_flag();
        // R5 add saturation both ways, R6 wrap
        apply(32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 1, 0, 0);
        apply(32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 1, 0, 0);
        clear_flag();
        apply(32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 0, 0, 0);
        check("R6 wrap", result, 32'h8000_0000);
        // R9 write beats same-cycle overflow, and can set the flag
        apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 1, 1, 0);
        apply(32'h0000_0000, 32'h0000_0000, 0, 0, 1, 1, 1);
        clear_flag();
        // R7 one lane overflows, other does not
        apply(32'h0001_7FFF, 32'h0001_0001, 0, 1, 1, 0, 0);
        check("R7 lane independence", result, 32'h0002_7FFF);
        // R10 hold with in_valid low
        @(negedge clk);
        op_a = 32'h1111_1111; op_b = 32'h2222_2222; op_sub = 0;
        @(negedge clk);
        check("R10 hold", result, res_exp);

        for (int i = 0; i < 600; i++) begin
            bit we;
            we = ($urandom_range(0, 15) == 0);
            apply(pick(), pick(), 1'($urandom), 1'($urandom), 1'($urandom),
                  we, 1'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule